// File: doc/BRIEF.md
# Seeded Pseudo-Random Receive Frame Checker

This block sits on the user side of a serial link receiver and checks received traffic for integrity. The transmit side fills its frames from a 16-bit linear feedback shift register that starts from a fixed seed. The checker runs its own copy of the same register from the same seed, so it can predict every word that should arrive. Each 64-bit word it expects is the current register state repeated four times.

Three receive channels are checked: the main stream data path, a user flow-control message path and a user K-character block path. Each channel has its own reference register, which steps only on beats of that channel. A data-path mismatch adds one to an 8-bit error count that saturates. A mismatch on either side channel sets a sticky flag for that channel.

While the link-up input is low, every reference register is held at the seed and nothing is compared. This lets a fresh run of traffic start cleanly after the link comes back.

Top module: `frame_chk_top`

## Requirements
- R1: While `rst` is high on a rising edge, `data_err_cnt` becomes 0, `fc_err` and `kblk_err` become 0, and every channel's reference register becomes the seed 16'hABCD.
- R2: The reference register steps by shifting left one bit and inserting at bit 0 the XOR of bits 15, 4, 3 and 2 (polynomial x^16+x^5+x^4+x^3+1). The expected word is the state in bits [15:0], [31:16], [47:32] and [63:48], so a flip of any of the 64 bits counts as a mismatch.
- R3: A data beat is a rising edge with `link_up` and `rx_tvalid` both high. A data beat whose `rx_tdata` differs from the expected word adds one to `data_err_cnt` at that same edge. A matching beat leaves the count unchanged.
- R4: A channel's reference register steps once per beat of that channel, whether the beat matched or not. Cycles with valid low do not step it.
- R5: `data_err_cnt` stops at 255 and stays there until reset.
- R6: A beat on the flow-control channel (`link_up` and `fc_valid` high) whose `fc_data` differs from that channel's expected word sets `fc_err`. The flag stays at 1 until reset.
- R7: A beat on the K-character channel (`link_up` and `kblk_valid` high) whose `kblk_data` differs from that channel's expected word sets `kblk_err`. The flag stays at 1 until reset.
- R8: Traffic on one channel does not step or affect the reference register of any other channel.
- R9: On any rising edge with `link_up` low, every reference register returns to the seed and no comparison is made, so the outputs do not change whatever the data and valid inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | High while the channel is up; low holds the references at the seed |
| rx_tvalid | input | 1 | Stream data beat valid |
| rx_tdata | input | 64 | Stream data word |
| fc_valid | input | 1 | Flow-control message word valid |
| fc_data | input | 64 | Flow-control message word |
| kblk_valid | input | 1 | K-character block word valid |
| kblk_data | input | 64 | K-character block word |
| data_err_cnt | output | 8 | Saturating count of mismatched stream data words |
| fc_err | output | 1 | Sticky flow-control mismatch flag |
| kblk_err | output | 1 | Sticky K-character mismatch flag |

## Verification
Every result is registered at the same rising edge that captures the beat. The count or flag caused by a mismatched beat is therefore visible right after that edge, and a matching beat or a link-down cycle leaves the outputs as they were at that edge. The bench drives inputs just after a falling edge and compares all three outputs against its own model at the next falling edge, so each beat's effect is checked exactly one edge after it is presented. Gaps, single-bit flips in every lane, link drops and a long error burst move the model and the design through the same sequence of edges.

// File: rtl/fchk_pkg.sv
package fchk_pkg;

    parameter int            LFSR_W = 16;
    parameter logic [15:0]   SEED   = 16'hABCD;
    parameter logic [15:0]   TAPS   = 16'h801C;   // bits 15,4,3,2
    parameter int            WORD_W = 64;
    parameter int            CNT_W  = 8;
    parameter int            NCH    = 3;

    localparam int REPS    = WORD_W / LFSR_W;
    localparam int CH_DATA = 0;
    localparam int CH_FC   = 1;
    localparam int CH_KBLK = 2;

    typedef logic [LFSR_W-1:0] lfsr_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  valid;
        word_t data;
    } beat_t;

    function automatic lfsr_t lfsr_step(input lfsr_t s);
        return {s[LFSR_W-2:0], ^(s & TAPS)};
    endfunction

    function automatic word_t widen(input lfsr_t s);
        word_t w;
        for (int i = 0; i < REPS; i++) begin
            w[i*LFSR_W +: LFSR_W] = s;
        end
        return w;
    endfunction

endpackage

// File: rtl/prbs_track.sv
module prbs_track import fchk_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  link_up,
    input  logic  adv,
    output lfsr_t state
);

    always_ff @(posedge clk) begin
        if (rst || !link_up) begin
            state <= SEED;
        end else if (adv) begin
            state <= lfsr_step(state);
        end
    end

    // R9: link down forces the seed
    p_seed_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !link_up |=> state == SEED);

    // R4: no beat, no step
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (link_up && !adv) |=> state == $past(state));

    // R4: a beat always moves the register (no all-zero lock)
    p_beat_moves_r4: assert property (@(posedge clk) disable iff (rst)
        (link_up && adv) |=> state != $past(state));

endmodule

// File: rtl/chan_check.sv
module chan_check import fchk_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  link_up,
    input  beat_t beat,
    output logic  miss
);

    lfsr_t ref_state;
    logic  take;

    assign take = link_up && beat.valid;

    prbs_track u_ref (
        .clk     (clk),
        .rst     (rst),
        .link_up (link_up),
        .adv     (beat.valid),
        .state   (ref_state)
    );

    always_comb begin
        miss = take && (beat.data != widen(ref_state));
    end

endmodule

// File: rtl/err_count.sv
module err_count import fchk_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (hit && cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: full count holds
    p_sat_hold_r5: assert property (@(posedge clk) disable iff (rst)
        cnt == TOP |=> cnt == TOP);

    // R3: count moves only upward by one
    p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
        cnt != $past(cnt) |-> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end
    end

    // R6 R7: once set, stays set
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        flag |=> flag);

endmodule

// File: rtl/frame_chk_top.sv
module frame_chk_top import fchk_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             link_up,
    input  logic             rx_tvalid,
    input  logic [63:0]      rx_tdata,
    input  logic             fc_valid,
    input  logic [63:0]      fc_data,
    input  logic             kblk_valid,
    input  logic [63:0]      kblk_data,
    output logic [7:0]       data_err_cnt,
    output logic             fc_err,
    output logic             kblk_err
);

    beat_t          beats [NCH];
    logic [NCH-1:0] miss;

    always_comb begin
        beats[CH_DATA] = '{valid: rx_tvalid,  data: rx_tdata};
        beats[CH_FC]   = '{valid: fc_valid,   data: fc_data};
        beats[CH_KBLK] = '{valid: kblk_valid, data: kblk_data};
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        chan_check u_chk (
            .clk     (clk),
            .rst     (rst),
            .link_up (link_up),
            .beat    (beats[c]),
            .miss    (miss[c])
        );
    end

    err_count u_cnt (
        .clk (clk),
        .rst (rst),
        .hit (miss[CH_DATA]),
        .cnt (data_err_cnt)
    );

    sticky_flag u_fc (
        .clk  (clk),
        .rst  (rst),
        .hit  (miss[CH_FC]),
        .flag (fc_err)
    );

    sticky_flag u_kb (
        .clk  (clk),
        .rst  (rst),
        .hit  (miss[CH_KBLK]),
        .flag (kblk_err)
    );

    // R9: no comparison while the link is down
    p_down_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !link_up |=> (data_err_cnt == $past(data_err_cnt))
                     && (fc_err == $past(fc_err))
                     && (kblk_err == $past(kblk_err)));

    // R3: the count never moves without a valid data beat
    p_cnt_needs_beat_r3: assert property (@(posedge clk) disable iff (rst)
        !rx_tvalid |=> data_err_cnt == $past(data_err_cnt));

    // R1: reset clears every output
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (data_err_cnt == '0) && !fc_err && !kblk_err);

endmodule

// File: tb/sim_frame_chk_top.sv
`timescale 1ns/1ps
module sim_frame_chk_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_up = 1'b0;
    logic        rx_tvalid = 1'b0, fc_valid = 1'b0, kblk_valid = 1'b0;
    logic [63:0] rx_tdata = '0, fc_data = '0, kblk_data = '0;
    logic [7:0]  data_err_cnt;
    logic        fc_err, kblk_err;

    always #10 clk = ~clk;   // 50 MHz

    frame_chk_top u0 (
        .clk(clk), .rst(rst), .link_up(link_up),
        .rx_tvalid(rx_tvalid), .rx_tdata(rx_tdata),
        .fc_valid(fc_valid), .fc_data(fc_data),
        .kblk_valid(kblk_valid), .kblk_data(kblk_data),
        .data_err_cnt(data_err_cnt), .fc_err(fc_err), .kblk_err(kblk_err)
    );

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // behavioural model state
    logic [15:0] gen [3];
    int          m_cnt;
    bit          m_fc, m_kb;

    function automatic logic [15:0] nxt(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[4] ^ s[3] ^ s[2]};
    endfunction

    function automatic logic [63:0] rep4(input logic [15:0] s);
        return {s, s, s, s};
    endfunction

    task automatic compare();
        checks++;
        if (data_err_cnt !== 8'(m_cnt)) begin
            fails++;
            $display("FAIL %s data_err_cnt actual=%0d expected=%0d", tag, data_err_cnt, m_cnt);
        end
        checks++;
        if (fc_err !== m_fc) begin
            fails++;
            $display("FAIL %s R6 fc_err actual=%0b expected=%0b", tag, fc_err, m_fc);
        end
        checks++;
        if (kblk_err !== m_kb) begin
            fails++;
            $display("FAIL %s R7 kblk_err actual=%0b expected=%0b", tag, kblk_err, m_kb);
        end
    endtask

    // one clock: check previous result, then present new inputs and update the model
    task automatic step(input bit lk, input bit [2:0] v,
                        input logic [63:0] f0, input logic [63:0] f1, input logic [63:0] f2);
        logic [63:0] flips [3];
        @(negedge clk);
        compare();
        flips[0] = f0; flips[1] = f1; flips[2] = f2;
        link_up    = lk;
        rx_tvalid  = v[0]; rx_tdata  = rep4(gen[0]) ^ f0;
        fc_valid   = v[1]; fc_data   = rep4(gen[1]) ^ f1;
        kblk_valid = v[2]; kblk_data = rep4(gen[2]) ^ f2;
        for (int c = 0; c < 3; c++) begin
            if (!lk) begin
                gen[c] = 16'hABCD;
            end else if (v[c]) begin
                if (flips[c] != '0) begin
                    if (c == 0 && m_cnt < 255) m_cnt++;
                    if (c == 1) m_fc = 1'b1;
                    if (c == 2) m_kb = 1'b1;
                end
                gen[c] = nxt(gen[c]);
            end
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int c = 0; c < 3; c++) gen[c] = 16'hABCD;
        m_cnt = 0; m_fc = 0; m_kb = 0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        tag = "R1";
        step(1'b0, 3'b000, '0, '0, '0);

        // R9: corrupted beats while link is down are ignored
        tag = "R9";
        for (int i = 0; i < 6; i++) step(1'b0, 3'b111, 64'h1 << i, 64'hFF, 64'h8000_0000_0000_0000);

        // R2 R4: clean traffic with gaps, all channels
        tag = "R2 R4";
        for (int i = 0; i < 40; i++) step(1'b1, 3'(i % 8), '0, '0, '0);

        // R2 R3: single-bit flips in every lane of the data path
        tag = "R2 R3";
        for (int i = 0; i < 12; i++) begin
            step(1'b1, 3'b001, 64'h1 << (i * 17 % 64), '0, '0);
            step(1'b1, 3'b001, '0, '0, '0);
        end
        step(1'b1, 3'b001, 64'h8000_0000_0000_0000, '0, '0);
        step(1'b1, 3'b001, 64'h0001_0000_0000_0000, '0, '0);

        // R8: only the data channel moves, then side channels must still match
        tag = "R8";
        for (int i = 0; i < 9; i++) step(1'b1, 3'b001, '0, '0, '0);
        for (int i = 0; i < 5; i++) step(1'b1, 3'b110, '0, '0, '0);

        // R6: flow-control mismatch sets sticky flag
        tag = "R6";
        step(1'b1, 3'b010, '0, 64'h0000_0000_0010_0000, '0);
        for (int i = 0; i < 4; i++) step(1'b1, 3'b011, '0, '0, '0);

        // R7: K-character mismatch sets sticky flag
        tag = "R7";
        step(1'b1, 3'b100, '0, '0, 64'h0000_0400_0000_0000);
        for (int i = 0; i < 4; i++) step(1'b1, 3'b111, '0, '0, '0);

        // R9: link drop mid-stream reseeds, traffic resumes clean
        tag = "R9";
        step(1'b0, 3'b111, 64'h2, '0, '0);
        step(1'b0, 3'b000, '0, '0, '0);
        for (int i = 0; i < 10; i++) step(1'b1, 3'b111, '0, '0, '0);

        // R5: error burst past saturation
        tag = "R5";
        for (int i = 0; i < 300; i++) step(1'b1, 3'b001, 64'h1 << (i % 64), '0, '0);
        for (int i = 0; i < 4; i++) step(1'b1, 3'b001, '0, '0, '0);

        step(1'b1, 3'b000, '0, '0, '0);
        finish_run();
    end

endmodule